// File: doc/BRIEF.md
# Cache Line Error Retirement Controller

This block sits beside the data array of a set-associative cache whose words carry a single-error-correct, double-error-detect code. The ECC decoder reports each access that found an error. A report carries the set, the way, the kind of error, the line's dirty bit and the corrected data. The controller handles one report at a time and decides how to recover.

A correctable error is forwarded to the requester with the corrected data and written back to the same location. It also raises a saturating per-line error count. When that count reaches a software-written threshold, the line is purged and retired. An uncorrectable error purges and retires the line at once. After a purge, a clean line is reloaded from memory and a dirty line's data is returned tagged as poisoned. In instruction-cache mode the lines are never written, so an uncorrectable error becomes a plain refetch.

Retired lines appear in a per-line disable mask. Software can read the mask and save it, so the same lines stay disabled after a restart. The mask also filters lookup hits and replacement candidates. The last enabled way of a set is never retired.

The controller is built around one state machine with these states:
- `ST_IDLE`: waits for a report.
- `ST_FIX`: forwards the corrected data and issues the writeback.
- `ST_PURGE`: issues the purge.
- `ST_RELOAD`: requests a reload after a purge.
- `ST_POISON`: returns the poisoned data.
- `ST_REFETCH`: requests a refetch in instruction-cache mode.

The transitions are:
- IDLE→FIX on a correctable report.
- IDLE→PURGE on an uncorrectable report outside instruction mode.
- IDLE→REFETCH on an uncorrectable report in instruction mode.
- FIX→PURGE when the threshold is reached, otherwise FIX→IDLE.
- PURGE→POISON for a dirty line, otherwise PURGE→RELOAD.
- RELOAD, POISON and REFETCH each return to IDLE.

Top module: `line_retire_ctrl`

## Requirements
- R1: A correctable report (kind 2'b01) accepted at a clock edge gives exactly one cycle in which `fwd_valid`=1, `fwd_poison`=0 and `wb_valid`=1. In that cycle `fwd_data` and `wb_data` equal the reported data, and `wb_set`/`wb_way` equal the reported location.
- R2: Each correctable report adds one to the error count of its line (index set*WAYS+way). The count saturates at 2^CNT_W-1.
- R3: The threshold register resets to THRESH_INIT and is loaded from `thr_val` when `thr_wr`=1. A threshold of 0 turns count-based retirement off. With a nonzero threshold, if the incremented count is at least the threshold, a purge follows in the next cycle. Every purge clears the line's count.
- R4: An uncorrectable report (kind 2'b10) outside instruction mode gives a purge of that set and way in the cycle after acceptance.
- R5: After a purge, a clean line gets one `reload_valid` cycle for that set and way. A dirty line instead gets one cycle with `fwd_valid`=1 and `fwd_poison`=1 carrying the reported data, and no reload.
- R6: A purge sets bit set*WAYS+way of `dis_mask`, unless that way is the only enabled way of its set. Mask bits never clear except at reset.
- R7: With `icache_mode`=1 at acceptance, an uncorrectable report gives a single `reload_valid` cycle. There is no purge, no count change and no mask change.
- R8: `q_hit` equals `q_hit_raw` with the disabled ways of set `q_set` cleared. `q_alloc` marks the enabled ways of that set.
- R9: `rpt_busy` is high from the cycle after acceptance until the sequence ends. Reports presented while busy are not accepted. Reports of kind 2'b00 or 2'b11 are ignored. At most one of writeback, purge, reload and poison is active in any cycle.
- R10: After reset the block is idle, no request is active, `dis_mask` is all zero and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr | input | 1 | Threshold write strobe |
| thr_val | input | CNT_W | Threshold value to write |
| icache_mode | input | 1 | Array holds never-written lines |
| rpt_valid | input | 1 | Error report present |
| rpt_set | input | SET_W | Reported set |
| rpt_way | input | WAY_W | Reported way |
| rpt_kind | input | 2 | 01 correctable, 10 uncorrectable |
| rpt_dirty | input | 1 | Line holds modified data |
| rpt_data | input | DATA_W | Corrected (or raw) data word |
| rpt_busy | output | 1 | Sequence in progress, reports stalled |
| fwd_valid | output | 1 | Data returned to requester |
| fwd_poison | output | 1 | Returned data is poisoned |
| fwd_data | output | DATA_W | Returned data |
| wb_valid | output | 1 | Write corrected word back |
| wb_set | output | SET_W | Writeback set |
| wb_way | output | WAY_W | Writeback way |
| wb_data | output | DATA_W | Writeback data |
| purge_valid | output | 1 | Purge line request |
| purge_set | output | SET_W | Purge set |
| purge_way | output | WAY_W | Purge way |
| reload_valid | output | 1 | Reload / refetch request |
| reload_set | output | SET_W | Reload set |
| reload_way | output | WAY_W | Reload way |
| dis_mask | output | SETS*WAYS | Retired-line mask, bit set*WAYS+way |
| q_set | input | SET_W | Lookup set |
| q_hit_raw | input | WAYS | Tag-match vector for lookup |
| q_hit | output | WAYS | Hits filtered by the mask |
| q_alloc | output | WAYS | Ways eligible for replacement |

## Verification
The bench builds the block with SETS=4, WAYS=2, CNT_W=2 and THRESH_INIT=2. With only eight lines and a two-bit count, random reports push counts into saturation and reach the threshold often. With two ways per set, the last-way rule comes up within a few hundred reports. The threshold is rewritten during the random run, including to 0 and to the count's maximum. Saturation then becomes visible: a line that took several errors with retirement off retires on its next error once a threshold is set.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIX,
        ST_PURGE,
        ST_RELOAD,
        ST_POISON,
        ST_REFETCH
    } lrc_state_e;

    localparam logic [1:0] KIND_CE = 2'b01;
    localparam logic [1:0] KIND_UE = 2'b10;

endpackage

// File: rtl/lrc_err_counters.sv
module lrc_err_counters #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int CNT_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc_en,
    input  logic                       clr_en,
    input  logic [$clog2(SETS)-1:0]    sel_set,
    input  logic [$clog2(WAYS)-1:0]    sel_way,
    output logic [CNT_W-1:0]           cnt_next
);
    localparam int LINES  = SETS * WAYS;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LIDX_W = SET_W + WAY_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q [LINES];
    logic [LIDX_W-1:0] idx;
    logic [CNT_W-1:0]  cur;

    assign idx      = {sel_set, sel_way};
    assign cur      = cnt_q[idx];
    assign cnt_next = (cur == CNT_MAX) ? cur : cur + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                cnt_q[i] <= '0;
            end
        end else if (clr_en) begin
            cnt_q[idx] <= '0;
        end else if (inc_en) begin
            cnt_q[idx] <= cnt_next;
        end
    end

    // R2: a saturated count stays at its maximum after another increment
    p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !clr_en && cur == CNT_MAX) |=> (cur == CNT_MAX));

    // R3: a purge leaves the line's count at zero
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (cur == '0));

endmodule

// File: rtl/lrc_way_mask.sv
module lrc_way_mask #(
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       del_en,
    input  logic [$clog2(SETS)-1:0]    del_set,
    input  logic [$clog2(WAYS)-1:0]    del_way,
    input  logic [$clog2(SETS)-1:0]    q_set,
    input  logic [WAYS-1:0]            q_hit_raw,
    output logic [WAYS-1:0]            q_hit,
    output logic [WAYS-1:0]            q_alloc,
    output logic [SETS*WAYS-1:0]       mask
);
    localparam int LINES  = SETS * WAYS;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LIDX_W = SET_W + WAY_W;

    logic [LINES-1:0]  mask_q;
    logic [LIDX_W-1:0] del_idx;
    logic [WAYS-1:0]   del_row;
    logic [WAYS-1:0]   q_row;
    logic [WAY_W:0]    en_cnt;
    logic              del_ok;

    assign del_idx = {del_set, del_way};
    assign del_row = mask_q[{del_set, {WAY_W{1'b0}}} +: WAYS];
    assign q_row   = mask_q[{q_set, {WAY_W{1'b0}}} +: WAYS];

    always_comb begin
        en_cnt = '0;
        for (int w = 0; w < WAYS; w++) begin
            en_cnt = en_cnt + {{WAY_W{1'b0}}, ~del_row[w]};
        end
    end

    assign del_ok = (en_cnt > (WAY_W+1)'(1)) && !del_row[del_way];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (del_en && del_ok) begin
            mask_q[del_idx] <= 1'b1;
        end
    end

    assign q_hit   = q_hit_raw & ~q_row;
    assign q_alloc = ~q_row;
    assign mask    = mask_q;

    // R6: every set keeps at least one enabled way
    for (genvar s = 0; s < SETS; s++) begin : g_keep
        p_keep_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(&mask_q[s*WAYS +: WAYS]));
    end

    // R6: a permitted delete is visible in the mask one cycle later
    p_delete_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (del_en && del_ok) |=> mask_q[$past(del_idx)]);

    // R6: mask bits are sticky
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mask_q) & ~mask_q) == '0));

    // R8: a hit is never reported for a disabled way
    p_no_dead_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_hit & q_row) == '0));

endmodule

// File: rtl/lrc_fsm.sv
module lrc_fsm
    import lrc_pkg::*;
#(
    parameter int SET_W       = 4,
    parameter int WAY_W       = 2,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 3,
    parameter int THRESH_INIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic [CNT_W-1:0]  thr_val,
    input  logic              icache_mode,
    input  logic              rpt_valid,
    input  logic [SET_W-1:0]  rpt_set,
    input  logic [WAY_W-1:0]  rpt_way,
    input  logic [1:0]        rpt_kind,
    input  logic              rpt_dirty,
    input  logic [DATA_W-1:0] rpt_data,
    input  logic [CNT_W-1:0]  cnt_next,
    output logic              busy,
    output logic [SET_W-1:0]  cap_set,
    output logic [WAY_W-1:0]  cap_way,
    output logic [DATA_W-1:0] cap_data,
    output logic              fwd_valid,
    output logic              fwd_poison,
    output logic              wb_valid,
    output logic              purge_valid,
    output logic              reload_valid,
    output logic              cnt_inc
);
    lrc_state_e       st_q, st_d;
    logic [CNT_W-1:0] thr_q;
    logic             cap_dirty;
    logic             accept;
    logic             kind_ok;

    assign kind_ok = (rpt_kind == KIND_CE) || (rpt_kind == KIND_UE);
    assign accept  = (st_q == ST_IDLE) && rpt_valid && kind_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (rpt_kind == KIND_CE) begin
                        st_d = ST_FIX;
                    end else if (icache_mode) begin
                        st_d = ST_REFETCH;
                    end else begin
                        st_d = ST_PURGE;
                    end
                end
            end
            ST_FIX: begin
                if ((thr_q != '0) && (cnt_next >= thr_q)) begin
                    st_d = ST_PURGE;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_PURGE:   st_d = cap_dirty ? ST_POISON : ST_RELOAD;
            ST_RELOAD:  st_d = ST_IDLE;
            ST_POISON:  st_d = ST_IDLE;
            ST_REFETCH: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // report capture and threshold register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_set   <= '0;
            cap_way   <= '0;
            cap_data  <= '0;
            cap_dirty <= 1'b0;
            thr_q     <= CNT_W'(THRESH_INIT);
        end else begin
            if (accept) begin
                cap_set   <= rpt_set;
                cap_way   <= rpt_way;
                cap_data  <= rpt_data;
                cap_dirty <= rpt_dirty;
            end
            if (thr_wr) begin
                thr_q <= thr_val;
            end
        end
    end

    // outputs
    always_comb begin
        fwd_valid    = 1'b0;
        fwd_poison   = 1'b0;
        wb_valid     = 1'b0;
        purge_valid  = 1'b0;
        reload_valid = 1'b0;
        cnt_inc      = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_FIX: begin
                fwd_valid = 1'b1;
                wb_valid  = 1'b1;
                cnt_inc   = 1'b1;
            end
            ST_PURGE:   purge_valid  = 1'b1;
            ST_RELOAD:  reload_valid = 1'b1;
            ST_POISON: begin
                fwd_valid  = 1'b1;
                fwd_poison = 1'b1;
            end
            ST_REFETCH: reload_valid = 1'b1;
            default: ;
        endcase
    end

    assign busy = (st_q != ST_IDLE);

    // R9: captured location holds while a sequence runs
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cap_set) && $stable(cap_way)));

    // R9: request strobes are mutually exclusive
    p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, purge_valid, reload_valid, fwd_poison}));

    // R5: a dirty purge never leads to a reload
    p_dirty_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_valid && cap_dirty) |=> (fwd_poison && !reload_valid));

    // R5: a clean purge is followed by a reload
    p_clean_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_valid && !cap_dirty) |=> reload_valid);

endmodule

// File: rtl/line_retire_ctrl.sv
module line_retire_ctrl #(
    parameter int SETS        = 16,
    parameter int WAYS        = 4,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 3,
    parameter int THRESH_INIT = 2,
    localparam int SET_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  thr_wr,
    input  logic [CNT_W-1:0]      thr_val,
    input  logic                  icache_mode,
    input  logic                  rpt_valid,
    input  logic [SET_W-1:0]      rpt_set,
    input  logic [WAY_W-1:0]      rpt_way,
    input  logic [1:0]            rpt_kind,
    input  logic                  rpt_dirty,
    input  logic [DATA_W-1:0]     rpt_data,
    output logic                  rpt_busy,
    output logic                  fwd_valid,
    output logic                  fwd_poison,
    output logic [DATA_W-1:0]     fwd_data,
    output logic                  wb_valid,
    output logic [SET_W-1:0]      wb_set,
    output logic [WAY_W-1:0]      wb_way,
    output logic [DATA_W-1:0]     wb_data,
    output logic                  purge_valid,
    output logic [SET_W-1:0]      purge_set,
    output logic [WAY_W-1:0]      purge_way,
    output logic                  reload_valid,
    output logic [SET_W-1:0]      reload_set,
    output logic [WAY_W-1:0]      reload_way,
    output logic [SETS*WAYS-1:0]  dis_mask,
    input  logic [SET_W-1:0]      q_set,
    input  logic [WAYS-1:0]       q_hit_raw,
    output logic [WAYS-1:0]       q_hit,
    output logic [WAYS-1:0]       q_alloc
);
    logic [SET_W-1:0]  cap_set;
    logic [WAY_W-1:0]  cap_way;
    logic [DATA_W-1:0] cap_data;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_inc;

    lrc_fsm #(
        .SET_W(SET_W), .WAY_W(WAY_W), .DATA_W(DATA_W),
        .CNT_W(CNT_W), .THRESH_INIT(THRESH_INIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .thr_wr(thr_wr), .thr_val(thr_val), .icache_mode(icache_mode),
        .rpt_valid(rpt_valid), .rpt_set(rpt_set), .rpt_way(rpt_way),
        .rpt_kind(rpt_kind), .rpt_dirty(rpt_dirty), .rpt_data(rpt_data),
        .cnt_next(cnt_next), .busy(rpt_busy),
        .cap_set(cap_set), .cap_way(cap_way), .cap_data(cap_data),
        .fwd_valid(fwd_valid), .fwd_poison(fwd_poison), .wb_valid(wb_valid),
        .purge_valid(purge_valid), .reload_valid(reload_valid),
        .cnt_inc(cnt_inc)
    );

    lrc_err_counters #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc_en(cnt_inc), .clr_en(purge_valid),
        .sel_set(cap_set), .sel_way(cap_way),
        .cnt_next(cnt_next)
    );

    lrc_way_mask #(.SETS(SETS), .WAYS(WAYS)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .del_en(purge_valid), .del_set(cap_set), .del_way(cap_way),
        .q_set(q_set), .q_hit_raw(q_hit_raw),
        .q_hit(q_hit), .q_alloc(q_alloc), .mask(dis_mask)
    );

    assign fwd_data   = cap_data;
    assign wb_set     = cap_set;
    assign wb_way     = cap_way;
    assign wb_data    = cap_data;
    assign purge_set  = cap_set;
    assign purge_way  = cap_way;
    assign reload_set = cap_set;
    assign reload_way = cap_way;

    // R1: a writeback always travels with an unpoisoned forward
    p_fix_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (fwd_valid && !fwd_poison));

    // R4: a purge only happens during a busy sequence
    p_purge_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        purge_valid |-> rpt_busy);

endmodule

// File: tb/line_retire_ctrl_tb_top.sv
module line_retire_ctrl_tb_top;
    localparam int SETS = 4, WAYS = 2, DATA_W = 16, CNT_W = 2, TINIT = 2;
    localparam int SET_W = 2, WAY_W = 1, LINES = SETS * WAYS;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thr_wr = 1'b0;
    logic [CNT_W-1:0] thr_val = '0;
    logic icache_mode = 1'b0;
    logic rpt_valid = 1'b0;
    logic [SET_W-1:0] rpt_set = '0;
    logic [WAY_W-1:0] rpt_way = '0;
    logic [1:0] rpt_kind = '0;
    logic rpt_dirty = 1'b0;
    logic [DATA_W-1:0] rpt_data = '0;
    logic [SET_W-1:0] q_set = '0;
    logic [WAYS-1:0] q_hit_raw = '0;
    logic rpt_busy, fwd_valid, fwd_poison, wb_valid, purge_valid, reload_valid;
    logic [DATA_W-1:0] fwd_data, wb_data;
    logic [SET_W-1:0] wb_set, purge_set, reload_set;
    logic [WAY_W-1:0] wb_way, purge_way, reload_way;
    logic [LINES-1:0] dis_mask;
    logic [WAYS-1:0] q_hit, q_alloc;

    always #4 clk = ~clk;

    line_retire_ctrl #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W),
                       .CNT_W(CNT_W), .THRESH_INIT(TINIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_val(thr_val),
        .icache_mode(icache_mode), .rpt_valid(rpt_valid), .rpt_set(rpt_set),
        .rpt_way(rpt_way), .rpt_kind(rpt_kind), .rpt_dirty(rpt_dirty),
        .rpt_data(rpt_data), .rpt_busy(rpt_busy), .fwd_valid(fwd_valid),
        .fwd_poison(fwd_poison), .fwd_data(fwd_data), .wb_valid(wb_valid),
        .wb_set(wb_set), .wb_way(wb_way), .wb_data(wb_data),
        .purge_valid(purge_valid), .purge_set(purge_set), .purge_way(purge_way),
        .reload_valid(reload_valid), .reload_set(reload_set),
        .reload_way(reload_way), .dis_mask(dis_mask), .q_set(q_set),
        .q_hit_raw(q_hit_raw), .q_hit(q_hit), .q_alloc(q_alloc)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cnt_m [LINES];
    bit dis_m [LINES];
    int thr_m = TINIT;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int enabled_in(input int s);
        int n = 0;
        for (int w = 0; w < WAYS; w++) if (!dis_m[s*WAYS+w]) n++;
        return n;
    endfunction

    function automatic logic [LINES-1:0] mask_m();
        logic [LINES-1:0] m;
        for (int i = 0; i < LINES; i++) m[i] = dis_m[i];
        return m;
    endfunction

    function automatic logic [WAYS-1:0] row_m(input int s);
        logic [WAYS-1:0] r;
        for (int w = 0; w < WAYS; w++) r[w] = dis_m[s*WAYS+w];
        return r;
    endfunction

    task automatic write_thr(input int v);
        @(negedge clk);
        thr_wr = 1'b1;
        thr_val = CNT_W'(v);
        @(negedge clk);
        thr_wr = 1'b0;
        thr_m = v;
    endtask

    task automatic report(input int s, input int w, input int kind, input bit dirty,
                          input logic [DATA_W-1:0] d, input bit icm, input bit noise);
        int line = s * WAYS + w;
        int e_fix = 0, e_pur = 0, e_rel = 0, e_poi = 0, e_len;
        int n_fix = 0, n_wb = 0, n_pur = 0, n_rel = 0, n_poi = 0, bad = 0, len = 0;
        if (kind == 1) begin
            int nc = (cnt_m[line] == CMAX) ? CMAX : cnt_m[line] + 1;
            cnt_m[line] = nc;
            e_fix = 1;
            e_pur = (thr_m != 0 && nc >= thr_m) ? 1 : 0;
        end else if (icm) begin
            e_rel = 1;
        end else begin
            e_pur = 1;
        end
        if (e_pur == 1) begin
            if (dirty) e_poi = 1; else e_rel = 1;
            if (enabled_in(s) > 1 && !dis_m[line]) dis_m[line] = 1;
            cnt_m[line] = 0;
        end
        e_len = e_fix + e_pur + e_rel + e_poi;
        @(negedge clk);
        rpt_valid = 1'b1; rpt_set = SET_W'(s); rpt_way = WAY_W'(w);
        rpt_kind = 2'(kind); rpt_dirty = dirty; rpt_data = d; icache_mode = icm;
        @(negedge clk);
        if (noise) begin
            rpt_set = SET_W'(s + 1); rpt_kind = 2'b10; rpt_dirty = 1'b0;
        end else rpt_valid = 1'b0;
        while (rpt_busy && len < 12) begin
            if (fwd_valid && !fwd_poison) begin n_fix++; if (fwd_data !== d) bad++; end
            if (fwd_valid && fwd_poison) begin n_poi++; if (fwd_data !== d) bad++; end
            if (wb_valid) begin
                n_wb++;
                if (wb_set !== SET_W'(s) || wb_way !== WAY_W'(w) || wb_data !== d) bad++;
            end
            if (purge_valid) begin
                n_pur++;
                if (purge_set !== SET_W'(s) || purge_way !== WAY_W'(w)) bad++;
            end
            if (reload_valid) begin
                n_rel++;
                if (reload_set !== SET_W'(s) || reload_way !== WAY_W'(w)) bad++;
            end
            len++;
            if (!(noise && len < 2)) rpt_valid = 1'b0;
            @(negedge clk);
        end
        rpt_valid = 1'b0;
        chk(len == e_len, "R9", "busy cycles", len, e_len);
        chk(n_fix == e_fix && n_wb == e_fix, "R1", "forward/writeback count", n_wb, e_fix);
        chk(n_pur == e_pur, "R3 R4", "purge count", n_pur, e_pur);
        chk(n_rel == e_rel, "R5 R7", "reload count", n_rel, e_rel);
        chk(n_poi == e_poi, "R5", "poison count", n_poi, e_poi);
        chk(bad == 0, "R1 R5", "field mismatches", bad, 0);
        chk(dis_mask == mask_m(), "R6", "disable mask", dis_mask, mask_m());
    endtask

    task automatic ignored_kind(input int kind);
        @(negedge clk);
        rpt_valid = 1'b1; rpt_kind = 2'(kind); rpt_set = '0; rpt_way = '0;
        @(negedge clk);
        rpt_valid = 1'b0;
        chk(!rpt_busy && !wb_valid && !purge_valid && !reload_valid && !fwd_valid,
            "R9", "ignored kind activity", rpt_busy, 0);
    endtask

    task automatic lookup(input int s);
        @(negedge clk);
        q_set = SET_W'(s); q_hit_raw = '1;
        #1;
        chk(q_hit == ~row_m(s), "R8", "filtered hit", q_hit, ~row_m(s));
        chk(q_alloc == ~row_m(s), "R8", "alloc ways", q_alloc, ~row_m(s));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < LINES; i++) begin cnt_m[i] = 0; dis_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!rpt_busy && !wb_valid && !purge_valid && !reload_valid && !fwd_valid,
            "R10", "idle after reset", rpt_busy, 0);
        chk(dis_mask == '0, "R10", "mask after reset", dis_mask, 0);
        lookup(0);
        // R1 R2: first correctable error, count 1 below THRESH_INIT
        report(0, 0, 1, 1'b0, 16'hA5A5, 1'b0, 1'b0);
        // R3: second error reaches THRESH_INIT, clean retire, noise while busy (R9)
        report(0, 0, 1, 1'b0, 16'h1234, 1'b0, 1'b1);
        // R6 last-way rule, R5 poison
        report(0, 1, 2, 1'b1, 16'hBEEF, 1'b0, 1'b0);
        lookup(0);
        // R7 instruction mode
        report(1, 0, 2, 1'b0, 16'h0F0F, 1'b1, 1'b0);
        // R9 ignored kinds
        ignored_kind(0);
        ignored_kind(3);
        // R2 saturation with retirement off, then R3 re-enable
        write_thr(0);
        for (int k = 0; k < 5; k++) report(2, 0, 1, 1'b0, 16'(k), 1'b0, 1'b0);
        write_thr(CMAX);
        report(2, 0, 1, 1'b1, 16'h7777, 1'b0, 1'b0);
        chk(dis_mask[4] == 1'b1, "R2", "saturated line retired", dis_mask[4], 1);
        // random phase
        for (int n = 0; n < 300; n++) begin
            int r = int'($urandom_range(0, 19));
            if (r == 0) write_thr(int'($urandom_range(0, CMAX)));
            report(int'($urandom_range(0, SETS-1)), int'($urandom_range(0, WAYS-1)),
                   ($urandom_range(0, 3) == 0) ? 2 : 1, 1'($urandom_range(0, 1)),
                   16'($urandom), ($urandom_range(0, 7) == 0), 1'b0);
            if (r == 1) lookup(int'($urandom_range(0, SETS-1)));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule